// File: doc/BRIEF.md
# Condition and Special Register Move Unit

This unit carries out the four register-move instructions that connect the general-purpose register file to a 32-bit condition register and to a small bank of special registers. It receives one decoded-or-not 32-bit instruction word per cycle, together with the 64-bit value already read from the general register named in the instruction. It keeps the condition register and the special registers inside itself. Instructions that read state return a 64-bit write-back for the general register file. A write to the one reserved special-register number raises a trap instead of updating anything.

The special-register number in the instruction has its two 5-bit halves swapped. The lower-addressed half of the field, instr[20:16], is the low part of the number, and instr[15:11] is the high part. A condition-register write carries an 8-bit field-select mask. Each select bit enables one 4-bit field, so software can update any subset of the eight fields in one instruction.

Control is a three-state machine. S_IDLE means there is no result this cycle. S_WRITEBACK presents a write-back. S_TRAP signals a trap. A read instruction moves the machine into S_WRITEBACK. A write to the reserved number moves it into S_TRAP. Any other accepted word, or no word, moves it into S_IDLE. These transitions apply from every state, so a new instruction can be accepted in each cycle.

Top module: `sprcr_move_unit`

## Requirements
- R1: After reset, wb_valid and trap are low, and the condition register and every special register read as zero.
- R2: A word is acted on only when instr_valid is high, instr[31:26] equals 31, and instr[10:1] holds one of the extended codes 467 (write special), 339 (read special), 144 (write condition fields) or 19 (read condition). Any other word changes no state and produces neither a write-back nor a trap.
- R3: The special-register number is {instr[15:11], instr[20:16]}.
- R4: A write-special instruction naming number 13 raises trap for exactly the following cycle, updates no register and produces no write-back.
- R5: A write to a 64-bit special register stores the whole GPR operand. A write to a 32-bit special register stores only operand bits [31:0].
- R6: A read of a 64-bit special register returns it unchanged. A read of a 32-bit special register returns it zero-extended to 64 bits.
- R7: For a write-condition-fields instruction, field select bit instr[12+k] enables condition-register bits [4k+3:4k]. The new value is (operand[31:0] AND mask) OR (old value AND NOT mask).
- R8: A read-condition instruction returns the condition register in wb_data[31:0] with wb_data[63:32] zero.
- R9: Special-register numbers that are not implemented read as zero and ignore writes, without trapping. A read of number 13 also returns zero.
- R10: Each read instruction accepted on a clock edge gives exactly one cycle of wb_valid after that edge, with wb_reg set to instr[25:21]. State written by one instruction is seen by the instruction in the next cycle.
- R11: Write-condition-fields and read-condition words with instr[20] set are not recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction word is offered this cycle |
| instr | input | 32 | Instruction word |
| gpr_rdata | input | 64 | Value of the general register named in instr[25:21] |
| wb_valid | output | 1 | Write-back present for one cycle |
| wb_reg | output | 5 | Destination general register of the write-back |
| wb_data | output | 64 | Write-back value |
| trap | output | 1 | Reserved special-register write was attempted |

## Verification
The bench builds the unit with its default parameters. These give four special registers: numbers 1 and 256 are 32 bits wide, numbers 8 and 9 are 64 bits wide, and number 13 is the trapping number. With this set the swapped halves of the number can be observed: 256 has all its bits in the high half, while 8 and 9 have all their bits in the low half, so decoding the halves in the wrong order reaches a different register. Having both widths present lets the bench check truncation on writes and zero-extension on reads. Unused numbers 5, 13 and 1023 cover the silent reads and ignored writes.

// File: rtl/sprcr_pkg.sv
package sprcr_pkg;

    localparam int XLEN   = 64;
    localparam int CRLEN  = 32;
    localparam int ILEN   = 32;
    localparam int SPRN_W = 10;
    localparam int REG_W  = 5;
    localparam int NIB_W  = 4;
    localparam int FXM_W  = CRLEN / NIB_W;
    localparam int XO_W   = 10;

    localparam logic [5:0]      PRIMARY_OP = 6'd31;
    localparam logic [XO_W-1:0] XO_MTSPR   = 10'd467;
    localparam logic [XO_W-1:0] XO_MFSPR   = 10'd339;
    localparam logic [XO_W-1:0] XO_MTCRF   = 10'd144;
    localparam logic [XO_W-1:0] XO_MFCR    = 10'd19;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_MTSPR,
        OP_MFSPR,
        OP_MTCRF,
        OP_MFCR
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_W-1:0]  gpr;
        logic [SPRN_W-1:0] sprn;
        logic [FXM_W-1:0]  fxm;
    } dec_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WRITEBACK,
        S_TRAP
    } state_e;

endpackage

// File: rtl/sprcr_decode.sv
module sprcr_decode
    import sprcr_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);

    logic [5:0]      prim;
    logic [XO_W-1:0] xo;
    logic            resv;
    logic            unused_lsb;

    assign prim       = instr[31:26];
    assign xo         = instr[10:1];
    assign resv       = instr[20];
    assign unused_lsb = instr[0];

    always_comb begin
        dec.gpr  = instr[25:21];
        // number halves arrive swapped: upper half of the field is the low part
        dec.sprn = {instr[15:11], instr[20:16]};
        dec.fxm  = instr[19:12];
        dec.op   = OP_NONE;
        if (prim == PRIMARY_OP) begin
            unique case (xo)
                XO_MTSPR: dec.op = OP_MTSPR;
                XO_MFSPR: dec.op = OP_MFSPR;
                XO_MTCRF: dec.op = resv ? OP_NONE : OP_MTCRF;
                XO_MFCR:  dec.op = resv ? OP_NONE : OP_MFCR;
                default:  dec.op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/spr_bank.sv
module spr_bank
    import sprcr_pkg::*;
#(
    parameter int unsigned                N_SPR    = 4,
    parameter logic [N_SPR*SPRN_W-1:0]    SPR_IDS  = {10'd9, 10'd8, 10'd256, 10'd1},
    parameter logic [N_SPR-1:0]           SPR_IS64 = 4'b1100,
    parameter logic [SPRN_W-1:0]          TRAP_ID  = 10'd13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SPRN_W-1:0] wr_num,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [SPRN_W-1:0] rd_num,
    output logic [XLEN-1:0]   rd_data,
    output logic              trap_hit
);

    localparam int NARROW = XLEN / 2;

    logic [N_SPR-1:0][XLEN-1:0] rd_vec;

    assign trap_hit = wr_en && (wr_num == TRAP_ID);

    for (genvar i = 0; i < N_SPR; i++) begin : g_spr
        localparam logic [SPRN_W-1:0] ID = SPR_IDS[i*SPRN_W +: SPRN_W];
        logic sel_wr;
        logic sel_rd;
        assign sel_wr = wr_en && !trap_hit && (wr_num == ID);
        assign sel_rd = (rd_num == ID);

        if (SPR_IS64[i]) begin : g_w64
            logic [XLEN-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      q <= '0;
                else if (sel_wr) q <= wr_data;
            end
            assign rd_vec[i] = sel_rd ? q : '0;
        end else begin : g_w32
            logic [NARROW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      q <= '0;
                else if (sel_wr) q <= wr_data[NARROW-1:0];
            end
            assign rd_vec[i] = sel_rd ? {{(XLEN-NARROW){1'b0}}, q} : '0;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_SPR; i++) begin
            rd_data = rd_data | rd_vec[i];
        end
    end

endmodule

// File: rtl/cr_file.sv
module cr_file
    import sprcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [FXM_W-1:0] fxm,
    input  logic [CRLEN-1:0] wdata,
    output logic [CRLEN-1:0] cr
);

    logic [CRLEN-1:0] mask;
    logic [CRLEN-1:0] cr_r;

    for (genvar k = 0; k < FXM_W; k++) begin : g_mask
        assign mask[k*NIB_W +: NIB_W] = {NIB_W{fxm[k]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cr_r <= '0;
        else if (we) cr_r <= (wdata & mask) | (cr_r & ~mask);
    end

    assign cr = cr_r;

endmodule

// File: rtl/sprcr_move_unit.sv
module sprcr_move_unit
    import sprcr_pkg::*;
#(
    parameter int unsigned             N_SPR    = 4,
    parameter logic [N_SPR*SPRN_W-1:0] SPR_IDS  = {10'd9, 10'd8, 10'd256, 10'd1},
    parameter logic [N_SPR-1:0]        SPR_IS64 = 4'b1100,
    parameter logic [SPRN_W-1:0]       TRAP_SPR = 10'd13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [63:0]     gpr_rdata,
    output logic            wb_valid,
    output logic [4:0]      wb_reg,
    output logic [63:0]     wb_data,
    output logic            trap
);

    dec_t             dec;
    logic             spr_we;
    logic             cr_we;
    logic             spr_trap;
    logic [XLEN-1:0]  spr_rd;
    logic [CRLEN-1:0] cr_q;
    state_e           state_q;
    state_e           state_d;
    logic [XLEN-1:0]  wb_data_q;
    logic [REG_W-1:0] wb_reg_q;

    sprcr_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign spr_we = instr_valid && (dec.op == OP_MTSPR);
    assign cr_we  = instr_valid && (dec.op == OP_MTCRF);

    spr_bank #(
        .N_SPR    (N_SPR),
        .SPR_IDS  (SPR_IDS),
        .SPR_IS64 (SPR_IS64),
        .TRAP_ID  (TRAP_SPR)
    ) u_spr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (spr_we),
        .wr_num   (dec.sprn),
        .wr_data  (gpr_rdata),
        .rd_num   (dec.sprn),
        .rd_data  (spr_rd),
        .trap_hit (spr_trap)
    );

    cr_file u_cr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cr_we),
        .fxm   (dec.fxm),
        .wdata (gpr_rdata[CRLEN-1:0]),
        .cr    (cr_q)
    );

    // next state: the same launch rule applies from every state
    always_comb begin
        state_d = S_IDLE;
        if (instr_valid) begin
            unique case (dec.op)
                OP_MFSPR, OP_MFCR: state_d = S_WRITEBACK;
                OP_MTSPR:          state_d = spr_trap ? S_TRAP : S_IDLE;
                default:           state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_data_q <= '0;
            wb_reg_q  <= '0;
        end else if (instr_valid && (dec.op == OP_MFSPR)) begin
            wb_data_q <= spr_rd;
            wb_reg_q  <= dec.gpr;
        end else if (instr_valid && (dec.op == OP_MFCR)) begin
            wb_data_q <= {{(XLEN-CRLEN){1'b0}}, cr_q};
            wb_reg_q  <= dec.gpr;
        end
    end

    always_comb begin
        wb_valid = 1'b0;
        trap     = 1'b0;
        unique case (state_q)
            S_IDLE:      ;
            S_WRITEBACK: wb_valid = 1'b1;
            S_TRAP:      trap     = 1'b1;
            default:     ;
        endcase
    end

    assign wb_data = wb_data_q;
    assign wb_reg  = wb_reg_q;

endmodule

// File: rtl/sprcr_move_chk.sv
module sprcr_move_chk #(
    parameter logic [9:0] TRAP_SPR = 10'd13
) (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [31:0] instr,
    input logic        wb_valid,
    input logic [4:0]  wb_reg,
    input logic [63:0] wb_data,
    input logic        trap,
    input logic [31:0] cr_q
);

    logic       op31;
    logic [9:0] xo;
    logic       is_trap_wr;
    logic       is_read;
    logic       is_crread;
    logic       is_crwrite;

    assign op31       = instr_valid && (instr[31:26] == 6'd31);
    assign xo         = instr[10:1];
    assign is_trap_wr = op31 && (xo == 10'd467) && ({instr[15:11], instr[20:16]} == TRAP_SPR);
    assign is_crread  = op31 && (xo == 10'd19) && !instr[20];
    assign is_crwrite = op31 && (xo == 10'd144) && !instr[20];
    assign is_read    = (op31 && (xo == 10'd339)) || is_crread;

    a_r4_trap_source: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(is_trap_wr));

    a_r4_trap_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap && wb_valid));

    a_r10_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(is_read));

    a_r10_wb_dest: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_reg == $past(instr[25:21])));

    a_r8_cr_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(is_crread)) |-> (wb_data[63:32] == 32'd0));

    a_r7_cr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(is_crwrite) |-> $stable(cr_q));

    a_r2_foreign_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!op31) |-> (!wb_valid && !trap));

endmodule

bind sprcr_move_unit sprcr_move_chk #(.TRAP_SPR(TRAP_SPR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .wb_valid    (wb_valid),
    .wb_reg      (wb_reg),
    .wb_data     (wb_data),
    .trap        (trap),
    .cr_q        (cr_q)
);

// File: tb/sim_sprcr_move_unit.sv
`timescale 1ns/1ps
module sim_sprcr_move_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] gpr_rdata = '0;
    logic        wb_valid;
    logic [4:0]  wb_reg;
    logic [63:0] wb_data;
    logic        trap;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        bit          is_wb;
        bit          is_trap;
        logic [4:0]  rg;
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t exq[$];

    logic [63:0] m_spr [0:1023];
    logic [31:0] m_cr;

    sprcr_move_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .gpr_rdata   (gpr_rdata),
        .wb_valid    (wb_valid),
        .wb_reg      (wb_reg),
        .wb_data     (wb_data),
        .trap        (trap)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit impl(input logic [9:0] n);
        return (n == 10'd1) || (n == 10'd256) || (n == 10'd8) || (n == 10'd9);
    endfunction

    function automatic bit wide(input logic [9:0] n);
        return (n == 10'd8) || (n == 10'd9);
    endfunction

    function automatic logic [31:0] enc_mtspr(input logic [4:0] r, input logic [9:0] n);
        return {6'd31, r, n[4:0], n[9:5], 10'd467, 1'b0};
    endfunction
    function automatic logic [31:0] enc_mfspr(input logic [4:0] r, input logic [9:0] n);
        return {6'd31, r, n[4:0], n[9:5], 10'd339, 1'b0};
    endfunction
    function automatic logic [31:0] enc_mtcrf(input logic [4:0] r, input logic [7:0] f);
        return {6'd31, r, 1'b0, f, 1'b0, 10'd144, 1'b0};
    endfunction
    function automatic logic [31:0] enc_mfcr(input logic [4:0] r);
        return {6'd31, r, 1'b0, 9'd0, 10'd19, 1'b0};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (wb_valid=%0b trap=%0b wb_reg=%0d)",
                     tag, act, expv, wb_valid, trap, wb_reg);
        end
    endtask

    task automatic issue(input logic [31:0] iw, input logic [63:0] g, input string tag);
        exp_t e;
        logic [9:0] n;
        logic [9:0] xo;
        logic [31:0] mask;
        n  = {iw[15:11], iw[20:16]};
        xo = iw[10:1];
        e.due = cyc + 1; e.is_wb = 1'b0; e.is_trap = 1'b0;
        e.rg = iw[25:21]; e.data = '0; e.tag = tag;
        if (iw[31:26] == 6'd31) begin
            if (xo == 10'd467) begin
                if (n == 10'd13) e.is_trap = 1'b1;
                else if (impl(n)) m_spr[n] = wide(n) ? g : {32'd0, g[31:0]};
            end else if (xo == 10'd339) begin
                e.is_wb = 1'b1;
                e.data  = impl(n) ? m_spr[n] : 64'd0;
            end else if (xo == 10'd144 && !iw[20]) begin
                for (int k = 0; k < 8; k++) mask[4*k +: 4] = {4{iw[12+k]}};
                m_cr = (g[31:0] & mask) | (m_cr & ~mask);
            end else if (xo == 10'd19 && !iw[20]) begin
                e.is_wb = 1'b1;
                e.data  = {32'd0, m_cr};
            end
        end
        instr_valid = 1'b1;
        instr       = iw;
        gpr_rdata   = g;
        exq.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        instr_valid = 1'b0;
        instr       = '0;
        gpr_rdata   = '0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the item due this cycle and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (exq.size() > 0 && exq[0].due == cyc) begin
                exp_t e;
                e = exq.pop_front();
                if (e.is_wb)
                    check(wb_valid && !trap && wb_reg == e.rg && wb_data == e.data,
                          e.tag, wb_data, e.data);
                else if (e.is_trap)
                    check(trap && !wb_valid, e.tag, {62'd0, wb_valid, trap}, 64'd1);
                else
                    check(!wb_valid && !trap, e.tag, {62'd0, wb_valid, trap}, 64'd0);
            end else if (wb_valid || trap) begin
                check(1'b0, "R10 unexpected output", {62'd0, wb_valid, trap}, 64'd0);
            end
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) m_spr[i] = '0;
        m_cr = '0;
        repeat (3) @(negedge clk);
        check(!wb_valid && !trap, "R1 reset outputs", {62'd0, wb_valid, trap}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: state reads zero after reset
        issue(enc_mfcr(5'd3), '0, "R1 cr zero");
        issue(enc_mfspr(5'd4, 10'd8), '0, "R1 spr8 zero");
        issue(enc_mfspr(5'd4, 10'd256), '0, "R1 spr256 zero");
        idle(2);

        // R5 / R6 with back-to-back read (R10)
        issue(enc_mtspr(5'd2, 10'd8), 64'hDEAD_BEEF_1234_5678, "R5 wide write");
        issue(enc_mfspr(5'd6, 10'd8), '0, "R6 wide read R10 next cycle");
        issue(enc_mtspr(5'd2, 10'd1), 64'hFFFF_0000_A5A5_5A5A, "R5 narrow write");
        issue(enc_mfspr(5'd7, 10'd1), 64'hFFFF_FFFF_FFFF_FFFF, "R6 narrow zero-ext");
        idle(1);

        // R3: number 256 lives in the high half only
        issue(enc_mtspr(5'd3, 10'd256), 64'h0123_4567_89AB_CDEF, "R3 write 256");
        issue(enc_mfspr(5'd8, 10'd256), '0, "R3 read 256");
        issue(enc_mfspr(5'd9, 10'd8), '0, "R3 spr8 untouched");
        issue(enc_mtspr(5'd1, 10'd9), 64'h5555_AAAA_0F0F_F0F0, "R5 write 9");
        issue(enc_mfspr(5'd10, 10'd9), '0, "R6 read 9");
        idle(2);

        // R4: trapping number
        issue(enc_mtspr(5'd4, 10'd13), 64'hFFFF_FFFF_FFFF_FFFF, "R4 trap");
        idle(1);
        issue(enc_mfspr(5'd4, 10'd13), '0, "R9 read 13 zero");
        issue(enc_mfspr(5'd11, 10'd8), '0, "R4 spr8 kept");
        issue(enc_mfspr(5'd12, 10'd1), '0, "R4 spr1 kept");

        // R9: unimplemented numbers
        issue(enc_mtspr(5'd4, 10'd5), 64'hFFFF_FFFF_FFFF_FFFF, "R9 write 5 silent");
        issue(enc_mfspr(5'd13, 10'd5), '0, "R9 read 5 zero");
        issue(enc_mtspr(5'd4, 10'd1023), 64'hFFFF_FFFF_FFFF_FFFF, "R9 write 1023 silent");
        issue(enc_mfspr(5'd14, 10'd9), '0, "R9 spr9 kept");
        idle(2);

        // R7 / R8: field masks
        issue(enc_mtcrf(5'd5, 8'hFF), 64'hFFFF_FFFF_1234_5678, "R7 all fields");
        issue(enc_mfcr(5'd15), '0, "R8 read cr");
        issue(enc_mtcrf(5'd5, 8'h81), 64'h0000_0000_ABCD_EF01, "R7 top and bottom");
        issue(enc_mfcr(5'd16), '0, "R7 expect A2345671");
        issue(enc_mtcrf(5'd5, 8'h00), 64'hFFFF_FFFF_FFFF_FFFF, "R7 empty mask");
        issue(enc_mfcr(5'd17), '0, "R7 unchanged");
        issue(enc_mtcrf(5'd5, 8'h40), 64'h0000_0000_0F00_0000, "R7 one field");
        issue(enc_mfcr(5'd18), '0, "R8 expect AF345671");
        idle(1);

        // R2: foreign words
        issue({6'd30, 5'd3, 5'd8, 5'd0, 10'd339, 1'b0}, '0, "R2 other primary");
        issue({6'd31, 5'd3, 5'd8, 5'd0, 10'd266, 1'b0}, '0, "R2 other extended");
        issue({6'd31, 5'd3, 1'b0, 8'hFF, 1'b0, 10'd266, 1'b0}, 64'hFFFF_FFFF, "R2 no cr write");
        issue(enc_mfcr(5'd19), '0, "R2 cr unchanged");

        // R11: reserved bit set
        issue(enc_mfcr(5'd20) | 32'h0010_0000, '0, "R11 read ignored");
        issue(enc_mtcrf(5'd5, 8'hFF) | 32'h0010_0000, 64'd0, "R11 write ignored");
        issue(enc_mfcr(5'd21), '0, "R11 cr unchanged");

        // R10: consecutive reads each give one pulse
        issue(enc_mfcr(5'd22), '0, "R10 burst 1");
        issue(enc_mfspr(5'd23, 10'd256), '0, "R10 burst 2");
        issue(enc_mtspr(5'd6, 10'd9), 64'h1111_2222_3333_4444, "R10 write then read");
        issue(enc_mfspr(5'd24, 10'd9), '0, "R10 sees new value");
        idle(4);

        check(exq.size() == 0, "R10 all results seen", exq.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule